// File: doc/BRIEF.md
# USB Controller Interrupt Gatherer

This block sits between a USB OTG controller and the CPU interrupt controller. It latches per-endpoint transmit events, receive events and controller-level events (including a change of the VBUS-drive request) into one 32-bit pending-event word. It also holds an enable word, exposes the enabled subset of pending events and drives one level-sensitive interrupt request.

Software programs the enable word directly or through write-one-to-set and write-one-to-clear aliases. It can force pending bits through a write-one-to-set alias, for example to start polling from the VBUS-drive event. To acknowledge events, software reads the enabled view and writes that value back to the write-one-to-clear alias. Once the request line has fired, it cannot fire again until software writes the end-of-interrupt offset. Then a source that is left pending, or that re-arrives, never produces a request that software cannot see.

Top module: `usb_irq_gather`

## Requirements
- R1: Word offsets decode as follows: 0x20 pending (read), 0x24 pending-set, 0x28 pending-clear, 0x2C enable (read/write), 0x30 enable-set, 0x34 enable-clear, 0x38 enabled view (read), 0x3C end-of-interrupt. The aliases 0x24, 0x28, 0x30, 0x34, 0x3C and any other offset read as zero.
- R2: The implemented bits are transmit events at bits 4:0, receive events at bits 12:9 (receive endpoints 1 to 4), and controller events at bits 24:16, with the VBUS-drive event at bit 24. Every other bit, bit 8 included, reads zero and ignores writes. The implemented set is 0x01FF1E1F.
- R3: An event input that is high at a clock edge sets its pending bit at that edge. It wins over a pending-clear of the same bit written at the same edge.
- R4: Writing ones to pending-set (0x24) sets those pending bits. Zeros leave bits unchanged.
- R5: Writing ones to pending-clear (0x28) clears those pending bits. Zeros leave bits unchanged.
- R6: A write to 0x2C loads the enable word. Ones written to 0x30 set enable bits, and ones written to 0x34 clear them.
- R7: Offset 0x38 reads pending AND enable. A pending bit that is not enabled does not raise the request.
- R8: The request rises on the clock edge after the enabled view becomes nonzero while the gate is open. It stays high until the enabled view is zero, and falls on the edge after that.
- R9: Rising closes the gate. After the request falls it stays low, even with enabled events pending, until a write to 0x3C. The data of that write is ignored, and the request rises on the edge after that write if events are pending.
- R10: Reset clears pending and enable, holds the request low and opens the gate.
- R11: Offsets 0x20 and 0x38 are read-only. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tx_evt | input | 5 | Transmit endpoint events, endpoint 0 in bit 0 |
| rx_evt | input | 4 | Receive endpoint 1 to 4 events |
| core_evt | input | 9 | Controller events, VBUS-drive event in bit 8 |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a hardware event that lands on the same edge as a software clear of the same bit. In that case the set must win. The bench drives the event pulse and the pending-clear write from the same falling edge, so both meet at one rising edge. It then reads the pending word back. The other hard case is the gate after the request falls. The bench re-raises an enabled source, holds it for several cycles with no end-of-interrupt write, and watches the request stay low. It then writes 0x3C with arbitrary data and checks that the request rises on the next edge.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int REG_W = 32;

    localparam logic [7:0] OFS_SRC     = 8'h20;
    localparam logic [7:0] OFS_SRC_SET = 8'h24;
    localparam logic [7:0] OFS_SRC_CLR = 8'h28;
    localparam logic [7:0] OFS_MSK     = 8'h2C;
    localparam logic [7:0] OFS_MSK_SET = 8'h30;
    localparam logic [7:0] OFS_MSK_CLR = 8'h34;
    localparam logic [7:0] OFS_MASKED  = 8'h38;
    localparam logic [7:0] OFS_EOI     = 8'h3C;

    // one strobe per write target
    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_ld;
        logic msk_set;
        logic msk_clr;
        logic eoi;
    } wr_dec_t;

    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] msk;
    } reg_pair_t;

    typedef struct packed {
        logic irq;
        logic arm;
    } gate_t;

    function automatic logic [REG_W-1:0] field_mask(int lsb, int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lsb && i < lsb + n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/usb_irq_pack.sv
module usb_irq_pack
    import usb_irq_pkg::*;
#(
    parameter int N_TX     = 5,
    parameter int N_RX     = 4,
    parameter int N_CORE   = 9,
    parameter int TX_LSB   = 0,
    parameter int RX_LSB   = 9,
    parameter int CORE_LSB = 16
) (
    input  logic [N_TX-1:0]   tx_evt,
    input  logic [N_RX-1:0]   rx_evt,
    input  logic [N_CORE-1:0] core_evt,
    output logic [REG_W-1:0]  evt_vec
);

    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < N_TX; i++)   evt_vec[TX_LSB + i]   = tx_evt[i];
        for (int i = 0; i < N_RX; i++)   evt_vec[RX_LSB + i]   = rx_evt[i];
        for (int i = 0; i < N_CORE; i++) evt_vec[CORE_LSB + i] = core_evt[i];
    end

endmodule

// File: rtl/usb_irq_bus.sv
module usb_irq_bus
    import usb_irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  src,
    input  logic [REG_W-1:0]  msk,
    output wr_dec_t           dec,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [ADDR_W-1:0] A_SRC     = ADDR_W'(OFS_SRC);
    localparam logic [ADDR_W-1:0] A_SRC_SET = ADDR_W'(OFS_SRC_SET);
    localparam logic [ADDR_W-1:0] A_SRC_CLR = ADDR_W'(OFS_SRC_CLR);
    localparam logic [ADDR_W-1:0] A_MSK     = ADDR_W'(OFS_MSK);
    localparam logic [ADDR_W-1:0] A_MSK_SET = ADDR_W'(OFS_MSK_SET);
    localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(OFS_MSK_CLR);
    localparam logic [ADDR_W-1:0] A_MASKED  = ADDR_W'(OFS_MASKED);
    localparam logic [ADDR_W-1:0] A_EOI     = ADDR_W'(OFS_EOI);

    always_comb begin
        dec         = '0;
        dec.src_set = bus_wr && (bus_addr == A_SRC_SET);
        dec.src_clr = bus_wr && (bus_addr == A_SRC_CLR);
        dec.msk_ld  = bus_wr && (bus_addr == A_MSK);
        dec.msk_set = bus_wr && (bus_addr == A_MSK_SET);
        dec.msk_clr = bus_wr && (bus_addr == A_MSK_CLR);
        dec.eoi     = bus_wr && (bus_addr == A_EOI);
    end

    always_comb begin
        unique case (bus_addr)
            A_SRC:    rdata = src;
            A_MSK:    rdata = msk;
            A_MASKED: rdata = src & msk;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/usb_irq_state.sv
module usb_irq_state
    import usb_irq_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_dec_t          dec,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] evt_vec,
    output logic [REG_W-1:0] src_q,
    output logic [REG_W-1:0] msk_q
);

    reg_pair_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (dec.src_set) nxt_d.src = nxt_d.src | wdata;
        if (dec.src_clr) nxt_d.src = nxt_d.src & ~wdata;
        nxt_d.src = (nxt_d.src | evt_vec) & IMPL_MASK;   // hardware wins
        if (dec.msk_ld)  nxt_d.msk = wdata;
        if (dec.msk_set) nxt_d.msk = nxt_d.msk | wdata;
        if (dec.msk_clr) nxt_d.msk = nxt_d.msk & ~wdata;
        nxt_d.msk = nxt_d.msk & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign src_q = cur_q.src;
    assign msk_q = cur_q.msk;

endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_any,
    input  logic eoi,
    output logic irq_q,
    output logic arm_q
);

    gate_t cur_q, nxt_d;
    logic  rise_d;

    always_comb begin
        nxt_d  = cur_q;
        rise_d = !cur_q.irq && cur_q.arm && pend_any;
        if (cur_q.irq) begin
            nxt_d.irq = pend_any;
        end else if (rise_d) begin
            nxt_d.irq = 1'b1;
            nxt_d.arm = 1'b0;
        end
        if (eoi && !rise_d) nxt_d.arm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.irq <= 1'b0;
            cur_q.arm <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq_q = cur_q.irq;
    assign arm_q = cur_q.arm;

endmodule

// File: rtl/usb_irq_gather.sv
module usb_irq_gather
    import usb_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int N_TX     = 5,
    parameter int N_RX     = 4,
    parameter int N_CORE   = 9,
    parameter int TX_LSB   = 0,
    parameter int RX_LSB   = 9,
    parameter int CORE_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_TX-1:0]   tx_evt,
    input  logic [N_RX-1:0]   rx_evt,
    input  logic [N_CORE-1:0] core_evt,
    output logic              irq
);

    localparam logic [REG_W-1:0] IMPL_MASK = field_mask(TX_LSB, N_TX)
                                           | field_mask(RX_LSB, N_RX)
                                           | field_mask(CORE_LSB, N_CORE);

    wr_dec_t          dec;
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] src_q;
    logic [REG_W-1:0] msk_q;
    logic             gate_arm;
    logic             pend_any;

    usb_irq_pack #(
        .N_TX(N_TX), .N_RX(N_RX), .N_CORE(N_CORE),
        .TX_LSB(TX_LSB), .RX_LSB(RX_LSB), .CORE_LSB(CORE_LSB)
    ) u_pack (
        .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt), .evt_vec(evt_vec)
    );

    usb_irq_bus #(.ADDR_W(ADDR_W)) u_bus (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .src(src_q), .msk(msk_q),
        .dec(dec), .rdata(bus_rdata)
    );

    usb_irq_state #(.IMPL_MASK(IMPL_MASK)) u_state (
        .clk(clk), .rst_n(rst_n), .dec(dec), .wdata(bus_wdata),
        .evt_vec(evt_vec), .src_q(src_q), .msk_q(msk_q)
    );

    assign pend_any = |(src_q & msk_q);

    usb_irq_gate u_gate (
        .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .eoi(dec.eoi),
        .irq_q(irq), .arm_q(gate_arm)
    );

endmodule

// File: rtl/usb_irq_gather_chk.sv
module usb_irq_gather_chk #(
    parameter int          ADDR_W    = 8,
    parameter int          N_TX      = 5,
    parameter int          TX_LSB    = 0,
    parameter logic [31:0] IMPL_MASK = 32'h01FF1E1F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [N_TX-1:0]   tx_evt,
    input logic [31:0]       src,
    input logic [31:0]       msk,
    input logic              irq,
    input logic              arm
);

    localparam logic [ADDR_W-1:0] A_EOI     = ADDR_W'(8'h3C);
    localparam logic [ADDR_W-1:0] A_MSK_CLR = ADDR_W'(8'h34);

    p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == 32'h0);

    p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt != '0) |=> ((src[TX_LSB +: N_TX] & $past(tx_evt)) == $past(tx_evt)));

    p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MSK_CLR) |=> ((msk & $past(bus_wdata)) == 32'h0));

    p_rise_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((src & msk) != 32'h0));

    p_rise_closes_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !arm);

    p_no_refire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !arm) |=> !irq);

    p_eoi_reopens_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EOI) |=> (arm || irq));

endmodule

bind usb_irq_gather usb_irq_gather_chk #(
    .ADDR_W(ADDR_W), .N_TX(N_TX), .TX_LSB(TX_LSB), .IMPL_MASK(IMPL_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .src(src_q), .msk(msk_q), .irq(irq), .arm(gate_arm)
);

// File: tb/usb_irq_gather_tb.sv
module usb_irq_gather_tb;

    localparam logic [7:0] A_SRC = 8'h20, A_SSET = 8'h24, A_SCLR = 8'h28,
                           A_MSK = 8'h2C, A_MSET = 8'h30, A_MCLR = 8'h34,
                           A_MASKED = 8'h38, A_EOI = 8'h3C;
    localparam logic [31:0] IMPL = 32'h01FF1E1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [4:0]  tx_evt = '0;
    logic [3:0]  rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    usb_irq_gather u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .core_evt(core_evt), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'h0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cleanup();
        wr(A_SCLR, 32'hFFFF_FFFF);
        wr(A_MCLR, 32'hFFFF_FFFF);
        wr(A_EOI, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd(8'h20 + 8'(i * 4), v);
            check($sformatf("R10 R1 reset read offset %0h", 8'h20 + i * 4), v, 32'h0);
        end
        check("R10 irq low after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        cleanup();
        wr(A_SSET, 32'hFFFF_FFFF);
        rd(A_SRC, v);   check("R2 R4 pending implemented bits", v, IMPL);
        rd(A_SSET, v);  check("R1 set alias reads zero", v, 32'h0);
        wr(A_SCLR, 32'h0000_1E00);
        rd(A_SRC, v);   check("R5 clear of receive bits", v, IMPL & ~32'h0000_1E00);
        wr(A_SSET, 32'h0);
        rd(A_SRC, v);   check("R4 zero set leaves bits", v, IMPL & ~32'h0000_1E00);
        wr(A_SCLR, 32'hFFFF_FFFF);
        rd(A_SRC, v);   check("R5 clear all", v, 32'h0);
        wr(A_SRC, 32'hFFFF_FFFF);
        rd(A_SRC, v);   check("R11 pending read-only", v, 32'h0);
        wr(A_MASKED, 32'hFFFF_FFFF);
        rd(A_SRC, v);   check("R11 masked view write ignored", v, 32'h0);
        rd(A_MSK, v);   check("R11 masked view write leaves enable", v, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        cleanup();
        wr(A_MSK, 32'hFFFF_FFFF);
        rd(A_MSK, v);   check("R6 R2 enable load", v, IMPL);
        wr(A_MCLR, 32'h0000_001F);
        rd(A_MSK, v);   check("R6 enable clear", v, IMPL & ~32'h1F);
        wr(A_MSK, 32'h0000_0003);
        rd(A_MSK, v);   check("R6 enable reload", v, 32'h3);
        wr(A_MSET, 32'h0100_0100);
        rd(A_MSK, v);   check("R6 enable set, bit8 unimplemented", v, 32'h0100_0003);
        rd(A_MCLR, v);  check("R1 enable clear alias reads zero", v, 32'h0);
        wr(A_SSET, 32'h0000_0006);
        rd(A_MASKED, v); check("R7 enabled view", v, 32'h0000_0002);
        rd(A_SRC, v);   check("R7 pending unchanged", v, 32'h0000_0006);
    endtask

    task automatic t_events();
        logic [31:0] v;
        cleanup();
        @(negedge clk);
        tx_evt = 5'b00101; rx_evt = 4'b1010; core_evt = 9'h100;
        @(negedge clk);
        tx_evt = '0; rx_evt = '0; core_evt = '0;
        rd(A_SRC, v);   check("R2 R3 event positions", v, 32'h0100_1405);
        // clear on same edge as event: event wins
        @(negedge clk);
        tx_evt = 5'b00001; core_evt = 9'h001;
        bus_wr = 1'b1; bus_addr = A_SCLR; bus_wdata = 32'h0101_1401;
        @(negedge clk);
        tx_evt = '0; core_evt = '0; bus_wr = 1'b0; bus_wdata = 32'h0;
        rd(A_SRC, v);   check("R3 event wins over clear", v, 32'h0001_0005);
    endtask

    task automatic t_irq_off_mask();
        logic [31:0] v;
        cleanup();
        wr(A_MSK, 32'h0000_0001);
        wr(A_SSET, 32'h0100_0000);
        repeat (3) @(negedge clk);
        check("R7 disabled source no irq", {31'h0, irq}, 32'h0);
        rd(A_MASKED, v); check("R7 enabled view zero", v, 32'h0);
    endtask

    task automatic t_irq_gate();
        logic [31:0] v;
        cleanup();
        wr(A_MSK, 32'h0100_0000);
        wr(A_SSET, 32'h0100_0000);
        check("R8 irq not yet high", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R8 irq rises next edge", {31'h0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R8 irq held high", {31'h0, irq}, 32'h1);
        wr(A_SCLR, 32'h0100_0000);
        check("R8 irq still high one edge", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R8 irq falls after ack", {31'h0, irq}, 32'h0);
        wr(A_SSET, 32'h0100_0000);
        repeat (5) @(negedge clk);
        check("R9 no refire without EOI", {31'h0, irq}, 32'h0);
        rd(A_MASKED, v); check("R9 pending visible while gated", v, 32'h0100_0000);
        wr(A_EOI, 32'hDEAD_BEEF);
        check("R9 irq low at EOI edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq rises after EOI", {31'h0, irq}, 32'h1);
        rd(A_EOI, v);   check("R1 EOI reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_mask();
        t_events();
        t_irq_off_mask();
        t_irq_gate();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule